// File: doc/BRIEF.md
# I2C Segment-Display Register Core

This block is the receiving side of a segment-display driver that sits on a two-wire serial bus. It only receives, and it answers to one fixed 7-bit device address. The first byte after the address is a control byte. That byte sets the drive mode, picks a display bank and loads a 6-bit pointer. Every byte that follows is a segment byte. The low three pointer bits choose which of eight 8-bit storage registers the byte lands in. After each segment byte the pointer steps forward.

Several copies of the block can share one bus. Each copy has its own 3-bit position, set on pins. All copies decode the header bytes and step the same shared pointer. The upper pointer bits act as a device number, so a long burst moves from one copy to the next. A copy writes and acknowledges a segment byte only while the pointer names it.

A small output multiplexer turns the eight registers into two 32-bit segment words, one for each backplane phase. Backplane waveforms and the oscillator are outside this block.

Top module: `segdisp_i2c_core`

## Requirements
- R1: The block acknowledges an address byte only when it equals 0111010 followed by a 0 direction bit (byte value 0x74). Any other address byte gets no acknowledge, and every later byte is ignored until the next start condition.
- R2: After a matching address, the next byte is always acknowledged and is read as a control byte. Bit 7 is the mode (0 = single backplane, 1 = dual backplane), bit 6 is the bank and bits 5..0 are the pointer. The mode and the pointer are always taken from this byte. The bank is taken only when the new pointer selects this device.
- R3: In single-backplane mode the device is selected when pointer bits 5..3 equal the sub-address pins. In dual-backplane mode pointer bit 5 is ignored, and only bits 4..3 are compared with pins 1..0.
- R4: A segment byte received while the device is selected is written to the register numbered by pointer bits 2..0 and is acknowledged. When the device is not selected, the byte is neither written nor acknowledged.
- R5: After every segment byte, selected or not, the pointer advances by 2 in single-backplane mode and by 1 in dual-backplane mode. It wraps from 63 to 0, so a burst can run from one device into the next.
- R6: A stop condition right after the control byte's acknowledge changes the bank without touching any segment register.
- R7: A start condition at any point makes the receiver expect an address byte. A byte cut short by that start has no effect.
- R8: In single-backplane mode, byte k of `seg_bp1_o` is register 2k+bank and `seg_bp2_o` is all zeros.
- R9: In dual-backplane mode, byte k of `seg_bp1_o` is register 2k and byte k of `seg_bp2_o` is register 2k+1. The bank has no effect.
- R10: After reset, all registers are zero, the mode is 0, the bank is 0, the pointer is 0 and the data line is not pulled low.
- R11: The acknowledge pull-down starts only at the SCL fall that ends the eighth bit and is released at the next SCL fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| sub_addr_i | input | 3 | Device position pins |
| sda_oe_o | output | 1 | When 1, the data line is pulled low (acknowledge) |
| mode_o | output | 1 | Latched drive mode, 1 = dual backplane |
| bank_o | output | 1 | Latched bank select |
| sbr_o | output | 64 | All eight registers, register i at bits 8i+7..8i |
| seg_bp1_o | output | 32 | Segment word for backplane 1 |
| seg_bp2_o | output | 32 | Segment word for backplane 2 |

## Verification
The assertions assume that SCL and SDA are slow next to the core clock. Each level is expected to stay put for more than the synchronizer depth plus one cycle. SDA is expected to move while SCL is high only to form a start or a stop. The bench keeps to this by holding every line level for ten core clocks per quarter bit. It changes data only after SCL has been low for that long, and it releases SDA across each acknowledge slot, which it models as a wired AND with the block's pull-down.

// File: rtl/segdisp_pkg.sv
`timescale 1ns/1ps
package segdisp_pkg;
    localparam int SEG_BYTE_W  = 8;
    localparam int SBR_COUNT   = 8;
    localparam int SBR_IDX_W   = $clog2(SBR_COUNT);
    localparam int SUB_W       = 3;
    localparam int VEC_W       = SBR_IDX_W + SUB_W;
    localparam int SEGS_PER_BP = SEG_BYTE_W * SBR_COUNT / 2;
    localparam int BIT_CNT_W   = $clog2(SEG_BYTE_W + 1);
    localparam logic [6:0] DEV_ADDR = 7'b0111010;

    typedef enum logic [1:0] {RX_IDLE, RX_ADDR, RX_CTRL, RX_DATA} rx_state_e;
    typedef enum logic {DRV_SINGLE = 1'b0, DRV_DUAL = 1'b1} drive_mode_e;

    // control byte layout: mode at bit 7, bank at bit 6, pointer below
    typedef struct packed {
        drive_mode_e      mode;
        logic             bank;
        logic [VEC_W-1:0] vec;
    } ctrl_word_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic                  en;
        logic [SBR_IDX_W-1:0]  idx;
        logic [SEG_BYTE_W-1:0] data;
    } sbr_wr_t;

    function automatic logic [VEC_W-1:0] vec_advance(input logic [VEC_W-1:0] v,
                                                     input drive_mode_e m);
        return v + ((m == DRV_DUAL) ? VEC_W'(1) : VEC_W'(2));
    endfunction

    function automatic logic dev_selected(input logic [VEC_W-1:0] v,
                                          input drive_mode_e m,
                                          input logic [SUB_W-1:0] sub);
        logic [SUB_W-1:0] hi;
        hi = v[VEC_W-1:SBR_IDX_W];
        if (m == DRV_DUAL) return hi[SUB_W-2:0] == sub[SUB_W-2:0];
        return hi == sub;
    endfunction
endpackage

// File: rtl/segdisp_line_sync.sv
`timescale 1ns/1ps
module segdisp_line_sync
    import segdisp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d, scl_s, sda_s;

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    always_comb begin
        evt_o.scl_rise = scl_s & ~scl_d;
        evt_o.scl_fall = ~scl_s & scl_d;
        evt_o.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt_o.stop     = scl_s & scl_d & ~sda_d & sda_s;
        evt_o.sda      = sda_s;
    end
endmodule

// File: rtl/segdisp_byte_engine.sv
`timescale 1ns/1ps
module segdisp_byte_engine
    import segdisp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt_i,
    input  logic [SUB_W-1:0] sub_i,
    output sbr_wr_t          wr_o,
    output drive_mode_e      mode_o,
    output logic             bank_o,
    output logic             sda_oe_o
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(SEG_BYTE_W - 1);

    rx_state_e             state_q;
    logic [SEG_BYTE_W-2:0] shift_q;
    logic [BIT_CNT_W-1:0]  bitcnt_q;
    logic                  byte_done_q, ack_pend_q, in_ack_q, sda_oe_q;
    logic [VEC_W-1:0]      vec_q;
    drive_mode_e           mode_q;
    logic                  bank_q;
    sbr_wr_t               wr_q;

    logic [SEG_BYTE_W-1:0] byte_w;
    ctrl_word_t            ctrl_w;
    logic                  bit_edge, last_bit, sel_now, ctrl_sel;

    assign byte_w   = {shift_q, evt_i.sda};
    assign ctrl_w   = ctrl_word_t'(byte_w);
    assign bit_edge = evt_i.scl_rise && (state_q != RX_IDLE) && !in_ack_q && !byte_done_q;
    assign last_bit = bit_edge && (bitcnt_q == LAST_BIT);
    assign sel_now  = dev_selected(vec_q, mode_q, sub_i);
    assign ctrl_sel = dev_selected(ctrl_w.vec, ctrl_w.mode, sub_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= RX_IDLE;
            shift_q     <= '0;
            bitcnt_q    <= '0;
            byte_done_q <= 1'b0;
            ack_pend_q  <= 1'b0;
            in_ack_q    <= 1'b0;
            sda_oe_q    <= 1'b0;
            vec_q       <= '0;
            mode_q      <= DRV_SINGLE;
            bank_q      <= 1'b0;
            wr_q        <= '0;
        end else begin
            wr_q.en <= 1'b0;
            if (evt_i.start) begin
                state_q     <= RX_ADDR;
                bitcnt_q    <= '0;
                byte_done_q <= 1'b0;
                in_ack_q    <= 1'b0;
                sda_oe_q    <= 1'b0;
            end else if (evt_i.stop) begin
                state_q     <= RX_IDLE;
                bitcnt_q    <= '0;
                byte_done_q <= 1'b0;
                in_ack_q    <= 1'b0;
                sda_oe_q    <= 1'b0;
            end else begin
                if (bit_edge) begin
                    shift_q  <= {shift_q[SEG_BYTE_W-3:0], evt_i.sda};
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
                if (last_bit) begin
                    byte_done_q <= 1'b1;
                    case (state_q)
                        RX_ADDR: begin
                            if (byte_w == {DEV_ADDR, 1'b0}) begin
                                ack_pend_q <= 1'b1;
                                state_q    <= RX_CTRL;
                            end else begin
                                ack_pend_q <= 1'b0;
                                state_q    <= RX_IDLE;
                            end
                        end
                        RX_CTRL: begin
                            ack_pend_q <= 1'b1;
                            mode_q     <= ctrl_w.mode;
                            vec_q      <= ctrl_w.vec;
                            if (ctrl_sel) bank_q <= ctrl_w.bank;
                            state_q    <= RX_DATA;
                        end
                        RX_DATA: begin
                            ack_pend_q <= sel_now;
                            if (sel_now) begin
                                wr_q.en   <= 1'b1;
                                wr_q.idx  <= vec_q[SBR_IDX_W-1:0];
                                wr_q.data <= byte_w;
                            end
                            vec_q <= vec_advance(vec_q, mode_q);
                        end
                        default: ack_pend_q <= 1'b0;
                    endcase
                end
                if (evt_i.scl_fall) begin
                    if (byte_done_q) begin
                        sda_oe_q    <= ack_pend_q;
                        in_ack_q    <= 1'b1;
                        byte_done_q <= 1'b0;
                    end else if (in_ack_q) begin
                        sda_oe_q <= 1'b0;
                        in_ack_q <= 1'b0;
                        bitcnt_q <= '0;
                    end
                end
            end
        end
    end

    assign wr_o     = wr_q;
    assign mode_o   = mode_q;
    assign bank_o   = bank_q;
    assign sda_oe_o = sda_oe_q;

    // R7
    start_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i.start |=> (state_q == RX_ADDR && bitcnt_q == '0 && !sda_oe_q));

    // R11
    ack_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_q) |-> $past(evt_i.scl_fall));

    // R5
    vec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (last_bit && state_q == RX_DATA) |=> (vec_q == vec_advance($past(vec_q), $past(mode_q))));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_IDLE && !in_ack_q) |-> !sda_oe_q);
endmodule

// File: rtl/segdisp_seg_store.sv
`timescale 1ns/1ps
module segdisp_seg_store
    import segdisp_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  sbr_wr_t                         wr_i,
    input  drive_mode_e                     mode_i,
    input  logic                            bank_i,
    output logic [SBR_COUNT*SEG_BYTE_W-1:0] regs_o,
    output logic [SEGS_PER_BP-1:0]          bp1_o,
    output logic [SEGS_PER_BP-1:0]          bp2_o
);
    logic [SEG_BYTE_W-1:0] sbr_q [SBR_COUNT];

    always_ff @(posedge clk) begin
        for (int i = 0; i < SBR_COUNT; i++) begin
            if (rst) sbr_q[i] <= '0;
            else if (wr_i.en && wr_i.idx == SBR_IDX_W'(i)) sbr_q[i] <= wr_i.data;
        end
    end

    for (genvar i = 0; i < SBR_COUNT; i++) begin : g_pack
        assign regs_o[i*SEG_BYTE_W +: SEG_BYTE_W] = sbr_q[i];
    end

    for (genvar k = 0; k < SBR_COUNT / 2; k++) begin : g_mux
        assign bp1_o[k*SEG_BYTE_W +: SEG_BYTE_W] =
            (mode_i == DRV_DUAL) ? sbr_q[2*k] : (bank_i ? sbr_q[2*k+1] : sbr_q[2*k]);
        assign bp2_o[k*SEG_BYTE_W +: SEG_BYTE_W] =
            (mode_i == DRV_DUAL) ? sbr_q[2*k+1] : '0;
    end

    // R4
    sbr_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i.en |=> (sbr_q[$past(wr_i.idx)] == $past(wr_i.data)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (regs_o == '0));
endmodule

// File: rtl/segdisp_i2c_core.sv
`timescale 1ns/1ps
module segdisp_i2c_core
    import segdisp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            scl_i,
    input  logic                            sda_i,
    input  logic [SUB_W-1:0]                sub_addr_i,
    output logic                            sda_oe_o,
    output logic                            mode_o,
    output logic                            bank_o,
    output logic [SBR_COUNT*SEG_BYTE_W-1:0] sbr_o,
    output logic [SEGS_PER_BP-1:0]          seg_bp1_o,
    output logic [SEGS_PER_BP-1:0]          seg_bp2_o
);
    bus_evt_t    evt;
    sbr_wr_t     wr;
    drive_mode_e mode_w;
    logic        bank_w;

    segdisp_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    segdisp_byte_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .sub_i    (sub_addr_i),
        .wr_o     (wr),
        .mode_o   (mode_w),
        .bank_o   (bank_w),
        .sda_oe_o (sda_oe_o)
    );

    segdisp_seg_store u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr),
        .mode_i (mode_w),
        .bank_i (bank_w),
        .regs_o (sbr_o),
        .bp1_o  (seg_bp1_o),
        .bp2_o  (seg_bp2_o)
    );

    assign mode_o = (mode_w == DRV_DUAL);
    assign bank_o = bank_w;

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sda_oe_o && !mode_o && !bank_o));
endmodule

// File: tb/segdisp_i2c_core_tb.sv
`timescale 1ns/1ps
module segdisp_i2c_core_tb;
    localparam int QT = 10;
    localparam int NTV = 7;
    // {sub[2:0], ctrl, data0, data1, ack0, ack1}
    localparam logic [28:0] TV [NTV] = '{
        {3'b010, 8'h10, 8'hAA, 8'h55, 1'b1, 1'b1},
        {3'b010, 8'h55, 8'h11, 8'h22, 1'b1, 1'b1},
        {3'b010, 8'h4E, 8'h33, 8'h44, 1'b0, 1'b1},
        {3'b010, 8'h16, 8'h66, 8'h77, 1'b1, 1'b0},
        {3'b010, 8'hB3, 8'h88, 8'h99, 1'b1, 1'b1},
        {3'b010, 8'h97, 8'h5A, 8'hA5, 1'b1, 1'b0},
        {3'b000, 8'h3E, 8'hC3, 8'h3C, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] sub = 3'b010;
    logic sda_bus;
    logic sda_oe, mode, bank;
    logic [63:0] sbr;
    logic [31:0] bp1, bp2;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] mdl [8];
    logic mdl_mode = 1'b0;
    logic mdl_bank = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    segdisp_i2c_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sub_addr_i (sub),
        .sda_oe_o   (sda_oe),
        .mode_o     (mode),
        .bank_o     (bank),
        .sbr_o      (sbr),
        .seg_bp1_o  (bp1),
        .seg_bp2_o  (bp2)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (QT) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        ack = ~sda_bus;
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    function automatic logic [63:0] mdl_pack();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = mdl[i];
        return v;
    endfunction

    function automatic logic sel_of(input logic [5:0] v, input logic m, input logic [2:0] s);
        return m ? (v[4:3] == s[1:0]) : (v[5:3] == s);
    endfunction

    // R8 R9: expected segment words from the model
    task automatic chk_outputs(input string tag);
        logic [31:0] e1, e2;
        for (int k = 0; k < 4; k++) begin
            if (mdl_mode) begin
                e1[k*8 +: 8] = mdl[2*k];
                e2[k*8 +: 8] = mdl[2*k+1];
            end else begin
                e1[k*8 +: 8] = mdl_bank ? mdl[2*k+1] : mdl[2*k];
                e2[k*8 +: 8] = 8'h00;
            end
        end
        chk({tag, " R8/R9 bp1"}, {32'h0, bp1}, {32'h0, e1});
        chk({tag, " R8/R9 bp2"}, {32'h0, bp2}, {32'h0, e2});
        chk({tag, " R4 regs"}, sbr, mdl_pack());
        chk({tag, " R2 mode"}, {63'h0, mode}, {63'h0, mdl_mode});
        chk({tag, " R2 bank"}, {63'h0, bank}, {63'h0, mdl_bank});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic a, a0, a1;
        logic [63:0] snap;
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        wait_q();

        // R10: reset state
        chk("R10 regs", sbr, 64'h0);
        chk("R10 oe/mode/bank", {61'h0, sda_oe, mode, bank}, 64'h0);
        chk("R10 bp1", {32'h0, bp1}, 64'h0);

        // Table walk: R2 R3 R4 R5 R8 R9
        for (int t = 0; t < NTV; t++) begin
            logic [28:0] e;
            logic [5:0]  v;
            logic [7:0]  c;
            logic [7:0]  d [2];
            logic        ea [2];
            e = TV[t];
            sub = e[28:26];
            c = e[25:18];
            d[0] = e[17:10];
            d[1] = e[9:2];
            ea[0] = e[1];
            ea[1] = e[0];
            bus_start();
            send_byte(8'h74, a);
            chk("R1 addr ack", {63'h0, a}, 64'h1);
            send_byte(c, a);
            chk("R2 ctrl ack", {63'h0, a}, 64'h1);
            v = c[5:0];
            mdl_mode = c[7];
            if (sel_of(v, c[7], sub)) mdl_bank = c[6];
            for (int j = 0; j < 2; j++) begin
                send_byte(d[j], a);
                chk("R3/R4 data ack", {63'h0, a}, {63'h0, ea[j]});
                if (sel_of(v, mdl_mode, sub)) mdl[v[2:0]] = d[j];
                v = v + (mdl_mode ? 6'd1 : 6'd2); // R5 step and wrap
            end
            bus_stop();
            wait_q();
            chk_outputs("table");
        end

        // R1: wrong address, then bytes ignored
        snap = sbr;
        bus_start();
        send_byte(8'h76, a);
        chk("R1 wrong addr", {63'h0, a}, 64'h0);
        send_byte(8'h00, a0);
        send_byte(8'hEE, a1);
        chk("R1 ignored acks", {62'h0, a0, a1}, 64'h0);
        bus_stop();
        wait_q();
        chk("R1 ignored regs", sbr, snap);

        // R1: read direction refused
        bus_start();
        send_byte(8'h75, a);
        chk("R1 read bit", {63'h0, a}, 64'h0);
        bus_stop();
        wait_q();

        // R6: bank-only update (sub=000, pointer 000000 selects)
        sub = 3'b000;
        snap = sbr;
        bus_start();
        send_byte(8'h74, a);
        send_byte(8'h40, a);
        bus_stop();
        wait_q();
        mdl_mode = 1'b0;
        mdl_bank = 1'b1;
        chk("R6 bank set", {63'h0, bank}, 64'h1);
        chk("R6 regs kept", sbr, snap);
        chk_outputs("R6");

        // R7: start in the middle of a data byte
        bus_start();
        send_byte(8'h74, a);
        send_byte(8'h02, a);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        chk("R7 partial no write", sbr, snap);
        send_byte(8'h74, a);
        chk("R7 addr after restart", {63'h0, a}, 64'h1);
        send_byte(8'h02, a);
        send_byte(8'hE7, a);
        chk("R7 data ack", {63'h0, a}, 64'h1);
        bus_stop();
        wait_q();
        mdl_bank = 1'b0;
        mdl[2] = 8'hE7;
        chk_outputs("R7");
        chk("R11 oe idle", {63'h0, sda_oe}, 64'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule